// File: doc/BRIEF.md
# DMA Status and Enable Register

This block holds the run and interrupt controls for two DMA channels behind one 8-bit CPU register. Software uses it to start each channel, to stop it, and to choose whether a channel that has finished raises an interrupt. Each channel's enable bit sits beside a guard bit in the same byte. The enable bit changes only when its guard bit is written as 0 in the same access. This lets software update one channel's enable without disturbing the other's.

A master enable sits above both channel enables and cannot be written directly. A permitted write of 1 to any channel enable sets it, even when that enable is already 1. An NMI clears it, which pauses all transfers while the NMI handler runs. A one-cycle termination strobe from a channel's transfer engine clears that channel's enable. The block drives one run enable per channel, which is the channel enable ANDed with the master enable. It also drives a single interrupt request that is high while any channel is stopped with its interrupt enabled.

The register is read through a combinational read-data bus that always shows the current state. Writes take effect at the rising clock edge. The register has no streaming interface, so all pins are plain control and status signals.

Top module: `dma_status_ctl`

## Requirements
- R1: After reset, rd_data is 8'h32, run_en is 2'b00 and irq is 0. Both channel enables, both interrupt enables and the master enable are 0.
- R2: A write changes the channel 1 enable (bit 7) only if bit 5 of the write data is 0, and the channel 0 enable (bit 6) only if bit 4 is 0. When the guard bit is 1, the enable keeps its value.
- R3: Bits 5, 4 and 1 of rd_data always read 1, whatever is written to them.
- R4: A permitted write of 1 to either channel enable sets the master enable (bit 0) to 1, even if that channel enable was already 1.
- R5: A permitted write of 0 to a channel enable clears that enable and leaves the master enable unchanged.
- R6: Bit 0 of the write data has no effect. The master enable changes only through R4 and R7.
- R7: A one-cycle pulse on nmi_pulse clears the master enable and leaves the channel enables unchanged. This takes priority over a master set by a write in the same cycle.
- R8: run_en[i] is 1 exactly when channel i's enable and the master enable are both 1.
- R9: irq is the OR over both channels of (enable is 0 AND interrupt enable is 1). It is combinational from the register state and forced to 0 while rst_n is low.
- R10: A one-cycle term_strobe[i] clears channel i's enable. It takes priority over a software write to that enable in the same cycle.
- R11: Every write loads the interrupt enables from bit 3 (channel 1) and bit 2 (channel 0), regardless of the guard bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents, combinational |
| nmi_pulse | input | 1 | Non-maskable interrupt event, clears the master enable |
| term_strobe | input | 2 | Per-channel transfer-termination strobe |
| run_en | output | 2 | Per-channel transfer permission |
| irq | output | 1 | DMA interrupt request |

## Verification
The bench checks that a guard bit of 1 blocks an enable write. A design that ignored the guard would start or stop the wrong channel. It rewrites an enable that is already 1 after an NMI and expects the master enable back. A design that set the master only on a 0-to-1 transition would leave every channel stalled after NMI service. It applies NMI and a setting write in the same cycle, and a termination strobe together with a write of 1. A wrong priority shows up as a master or channel enable left at 1. It also writes bit 0 and the constant bits, which a design that exposed them as storage would let change.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int REG_W     = 8;
  localparam int NCH       = 2;
  localparam int EN_LSB    = 6;
  localparam int GUARD_LSB = 4;
  localparam int IE_LSB    = 2;
  localparam int SPARE_BIT = 1;
  localparam int ME_BIT    = 0;
endpackage

// File: rtl/dmactl_chan.sv
module dmactl_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic en_bit,
  input  logic guard_bit,
  input  logic ie_bit,
  input  logic term,
  output logic en,
  output logic ie,
  output logic set_req
);
  logic wr_ok;

  // a channel write is honoured only with its guard cleared
  assign wr_ok   = wr_en & ~guard_bit;
  assign set_req = wr_ok & en_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      ie <= 1'b0;
    end else begin
      if (term)       en <= 1'b0;
      else if (wr_ok) en <= en_bit;
      if (wr_en)      ie <= ie_bit;
    end
  end
endmodule

// File: rtl/dmactl_master.sv
module dmactl_master #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_req,
  input  logic           nmi,
  output logic           me
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        me <= 1'b0;
    else if (nmi)      me <= 1'b0;
    else if (|set_req) me <= 1'b1;
  end
endmodule

// File: rtl/dmactl_rdmux.sv
module dmactl_rdmux
  import dma_stat_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic [N-1:0]     en,
  input  logic [N-1:0]     ie,
  input  logic             me,
  output logic [REG_W-1:0] rd
);
  always_comb begin
    rd = '1;
    for (int i = 0; i < N; i++) begin
      rd[EN_LSB+i] = en[i];
      rd[IE_LSB+i] = ie[i];
    end
    rd[ME_BIT] = me;
  end
endmodule

// File: rtl/dma_status_ctl.sv
module dma_status_ctl
  import dma_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             nmi_pulse,
  input  logic [NCH-1:0]   term_strobe,
  output logic [NCH-1:0]   run_en,
  output logic             irq
);
  logic [NCH-1:0] ch_en, ch_ie, ch_set;
  logic           master;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmactl_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .en_bit   (wr_data[EN_LSB+g]),
      .guard_bit(wr_data[GUARD_LSB+g]),
      .ie_bit   (wr_data[IE_LSB+g]),
      .term     (term_strobe[g]),
      .en       (ch_en[g]),
      .ie       (ch_ie[g]),
      .set_req  (ch_set[g])
    );
  end

  dmactl_master #(.NCH(NCH)) u_master (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(ch_set),
    .nmi    (nmi_pulse),
    .me     (master)
  );

  dmactl_rdmux #(.N(NCH)) u_rdmux (
    .en(ch_en),
    .ie(ch_ie),
    .me(master),
    .rd(rd_data)
  );

  assign run_en = ch_en & {NCH{master}};
  assign irq    = rst_n & (|(~ch_en & ch_ie));
endmodule

// File: rtl/dma_status_ctl_chk.sv
module dma_status_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       nmi_pulse,
  input logic [1:0] term_strobe,
  input logic [1:0] run_en,
  input logic       irq
);
  // R2
  guard0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && !term_strobe[0]) |=> (rd_data[6] == $past(rd_data[6])));
  // R3
  const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1] && wr_data[5:4] == 2'b00) |=> (rd_data[5:4] == 2'b11 && rd_data[1]));
  // R4
  master_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nmi_pulse && ((~wr_data[5:4] & wr_data[7:6]) != 2'b00)) |=> rd_data[0]);
  // R6
  master_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nmi_pulse && wr_data[0] && wr_data[5:4] == 2'b11) |=> (rd_data[0] == $past(rd_data[0])));
  // R7
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !rd_data[0]);
  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en == (rd_data[7:6] & {2{rd_data[0]}}));
  // R10
  term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_strobe != 2'b00) |=> ((rd_data[7:6] & $past(term_strobe)) == 2'b00));
  // R9
  always @(negedge clk) begin
    if (rst_n === 1'b0) irq_reset_chk: assert (irq == 1'b0);
  end
endmodule

bind dma_status_ctl dma_status_ctl_chk u_chk (.*);

// File: tb/dma_status_ctl_bench.sv
module dma_status_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       nmi_pulse = 1'b0;
  logic [1:0] term_strobe = '0;
  logic [7:0] rd_data;
  logic [1:0] run_en;
  logic       irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dma_status_ctl u_dma_status_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .nmi_pulse(nmi_pulse), .term_strobe(term_strobe),
    .run_en(run_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 0; nmi_pulse = 0; term_strobe = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d, input logic nmi, input logic [1:0] term);
    @(negedge clk); wr_en = 1'b1; wr_data = d; nmi_pulse = nmi; term_strobe = term;
    @(negedge clk); wr_en = 1'b0; nmi_pulse = 1'b0; term_strobe = '0;
  endtask

  task automatic pulse(input logic nmi, input logic [1:0] term);
    @(negedge clk); nmi_pulse = nmi; term_strobe = term;
    @(negedge clk); nmi_pulse = 1'b0; term_strobe = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd", rd_data, 8'h32);
    chk("R1 run", {6'd0, run_en}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_guard();
    do_reset();
    wr(8'hF0, 0, 2'b00);
    chk("R2 guarded", rd_data, 8'h32);
    wr(8'hD0, 0, 2'b00);
    chk("R2 one channel", rd_data, 8'hB3);
    chk("R8 run", {6'd0, run_en}, 8'h02);
  endtask

  task automatic t_consts();
    do_reset();
    wr(8'h31, 0, 2'b00);
    chk("R6 bit0 ignored", rd_data, 8'h32);
    wr(8'h00, 0, 2'b00);
    chk("R3 const bits", rd_data & 8'h32, 8'h32);
  endtask

  task automatic t_nmi();
    do_reset();
    wr(8'h90, 0, 2'b00);
    chk("R4 set", rd_data, 8'hB3);
    pulse(1'b1, 2'b00);
    chk("R7 nmi", rd_data, 8'hB2);
    chk("R8 run paused", {6'd0, run_en}, 8'h00);
    wr(8'h90, 0, 2'b00);
    chk("R4 rewrite 1", rd_data, 8'hB3);
    wr(8'h90, 1, 2'b00);
    chk("R7 nmi priority", rd_data, 8'hB2);
  endtask

  task automatic t_clear();
    do_reset();
    wr(8'hC0, 0, 2'b00);
    chk("R5 both on", rd_data, 8'hF3);
    wr(8'h20, 0, 2'b00);
    chk("R5 ch0 off", rd_data, 8'hB3);
    chk("R8 run", {6'd0, run_en}, 8'h02);
  endtask

  task automatic t_irq();
    do_reset();
    wr(8'h3C, 0, 2'b00);
    chk("R11 ie load", rd_data, 8'h3E);
    chk("R9 irq both idle", {7'd0, irq}, 8'h01);
    wr(8'h6C, 0, 2'b00);
    chk("R9 irq ch1 idle", {7'd0, irq}, 8'h01);
    wr(8'h9C, 0, 2'b00);
    chk("R9 irq none", {7'd0, irq}, 8'h00);
    pulse(1'b0, 2'b01);
    chk("R10 term ch0", rd_data, 8'hBF);
    chk("R9 irq after term", {7'd0, irq}, 8'h01);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9 irq in reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_term_prio();
    do_reset();
    wr(8'hC0, 0, 2'b00);
    wr(8'hC0, 0, 2'b10);
    chk("R10 term over write", rd_data, 8'h73);
    chk("R8 run", {6'd0, run_en}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_guard();
    t_consts();
    t_nmi();
    t_clear();
    t_irq();
    t_term_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule